// File: doc/BRIEF.md
# Shared-Controller Ownership Mutex Register

This block is a single advisory ownership register that several independent agents, such as firmware instances or virtual machines, use to agree on which of them may drive a shared serial-bus controller. Each agent has its own write port. To claim the controller, an agent writes its nonzero 4-bit identifier into the low field. It then reads the register back and owns the controller only when the owner field shows that same identifier.

The owner field is set only while the register is free. A claim from a different agent while the controller is held leaves the owner field unchanged, so the losing agent retries later. Any write of zero releases the register. The hardware checks no identity, so correct sharing depends on every agent leaving the holder alone.

When several ports write in the same clock, the lowest-numbered port's write is applied and the others are dropped. Read data is one shared word that every agent sees. A plain `owner_valid` pin reports whether any owner is recorded. The register bus carries no streamed data, so the ports are plain write strobes with no valid/ready handshake: a write is accepted in the cycle its strobe is high and never stalls.

Top module: `bus_owner_mutex`

## Requirements
- R1: After reset, `rd_data` reads 0 (request field bits [3:0] = 0, owner field bits [7:4] = 0) and `owner_valid` is 0.
- R2: When the owner field is 0 and the applied write carries a nonzero ID in bits [3:0], the owner field equals that ID from the next clock, and the request field equals it as well.
- R3: When the owner field is nonzero and the applied write carries a different nonzero ID, the owner field is unchanged and the request field takes the written ID.
- R4: A write of the ID that already equals the owner field keeps the owner field unchanged.
- R5: An applied write whose bits [3:0] are 0 clears both fields on the next clock, from any port, whatever ID is held.
- R6: When several ports write in one cycle, only the write of the lowest-numbered port among them is applied; the other writes have no effect.
- R7: `rd_data[31:8]` always reads 0, and bits [31:4] of a written word have no effect on either field.
- R8: `owner_valid` is 1 exactly when the owner field is nonzero.
- R9: In a cycle with no write, both fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | N_PORTS | Per-port write strobe, bit p for port p |
| wr_data | input | 32*N_PORTS | Per-port write word, port p in bits [32p+31:32p] |
| rd_data | output | 32 | Register read value: request in [3:0], owner in [7:4], rest zero |
| owner_valid | output | 1 | High while the owner field is nonzero |

## Verification
The bench builds the block with its default of three write ports. With three ports, one cycle can hold a winner and two dropped writes. It can also pair a release on one port with a claim on another, in either priority order. The random phase draws IDs from a small set that includes zero, so claims, conflicting claims, repeated claims and releases all occur often. Upper data bits are randomized so that writes to the unused bits are exercised throughout.

// File: rtl/busmtx_pkg.sv
package busmtx_pkg;
  localparam int REG_W   = 32;
  localparam int ID_W    = 4;
  localparam int REQ_LSB = 0;
  localparam int GNT_LSB = REQ_LSB + ID_W;
  localparam int USED_W  = 2 * ID_W;
  typedef logic [ID_W-1:0] agent_id_t;
endpackage

// File: rtl/busmtx_pick.sv
module busmtx_pick
  import busmtx_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       wr_en,
  input  logic [N_PORTS*REG_W-1:0] wr_data,
  output logic                     win_vld,
  output agent_id_t                win_id
);
  logic [N_PORTS-1:0] below;
  logic [N_PORTS-1:0] sel;
  agent_id_t          masked [N_PORTS];

  assign below[0] = 1'b0;
  for (genvar p = 1; p < N_PORTS; p++) begin : g_below
    assign below[p] = below[p-1] | wr_en[p-1];
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_sel
    assign sel[p]    = wr_en[p] & ~below[p];
    assign masked[p] = sel[p] ? wr_data[p*REG_W+REQ_LSB +: ID_W] : '0;
  end

  always_comb begin
    win_id = '0;
    for (int p = 0; p < N_PORTS; p++) win_id = win_id | masked[p];
  end
  assign win_vld = |sel;

  // R6: port 0 always wins when it writes
  p_port0_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |-> (win_vld && win_id == wr_data[REQ_LSB +: ID_W]));
  // R9: a winner exists exactly when some port writes
  p_vld_iff_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |-> !win_vld);
endmodule

// File: rtl/busmtx_state.sv
module busmtx_state
  import busmtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      win_vld,
  input  agent_id_t win_id,
  output agent_id_t req_q,
  output agent_id_t gnt_q
);
  agent_id_t req_d, gnt_d;

  always_comb begin
    req_d = req_q;
    gnt_d = gnt_q;
    if (win_vld) begin
      req_d = win_id;
      if (win_id == '0)      gnt_d = '0;
      else if (gnt_q == '0)  gnt_d = win_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      gnt_q <= '0;
    end else begin
      req_q <= req_d;
      gnt_q <= gnt_d;
    end
  end

  p_claim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_id != '0 && gnt_q == '0) |=> (gnt_q == $past(win_id)));
  p_hold_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_id != '0 && gnt_q != '0) |=> $stable(gnt_q));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_id == '0) |=> (gnt_q == '0 && req_q == '0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> ($stable(gnt_q) && $stable(req_q)));
endmodule

// File: rtl/bus_owner_mutex.sv
module bus_owner_mutex
  import busmtx_pkg::*;
#(
  parameter int N_PORTS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS-1:0]       wr_en,
  input  logic [N_PORTS*REG_W-1:0] wr_data,
  output logic [REG_W-1:0]         rd_data,
  output logic                     owner_valid
);
  logic      win_vld;
  agent_id_t win_id, req_q, gnt_q;

  busmtx_pick #(.N_PORTS(N_PORTS)) u_pick (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .win_vld(win_vld), .win_id(win_id)
  );

  busmtx_state u_state (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_id(win_id),
    .req_q(req_q), .gnt_q(gnt_q)
  );

  always_comb begin
    rd_data = '0;
    rd_data[REQ_LSB +: ID_W] = req_q;
    rd_data[GNT_LSB +: ID_W] = gnt_q;
  end
  assign owner_valid = |gnt_q;

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:USED_W] == '0);
  p_owner_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid == (rd_data[GNT_LSB +: ID_W] != '0));
endmodule

// File: tb/bus_owner_mutex_bench.sv
module bus_owner_mutex_bench;
  localparam int NP = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    wr_en = '0;
  logic [NP*32-1:0] wr_data = '0;
  logic [31:0]      rd_data;
  logic             owner_valid;
  int total = 0;
  int bad = 0;
  logic [3:0] m_req = 4'h0;
  logic [3:0] m_gnt = 4'h0;
  string tag = "R1";
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  bus_owner_mutex #(.N_PORTS(NP)) u_bus_owner_mutex (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .owner_valid(owner_valid)
  );

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 50000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=50000", cyc_cnt);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic check_all();
    chk(tag, {24'h0, rd_data[7:0]}, {24'h0, m_gnt, m_req});
    chk("R7", {8'h0, rd_data[31:8]}, 32'h0);
    chk("R8", {31'h0, owner_valid}, {31'h0, (m_gnt != 4'h0)});
  endtask

  // Reference: lowest writing port applied; bits [3:0] are the ID.
  task automatic apply(logic [NP-1:0] en, logic [NP*32-1:0] d);
    int w = -1;
    logic [3:0] id;
    for (int p = NP - 1; p >= 0; p--) if (en[p]) w = p;
    if (w < 0) begin
      tag = "R9";
      return;
    end
    id = d[w*32 +: 4];
    if (id == 4'h0) begin
      m_req = 4'h0; m_gnt = 4'h0; tag = "R5";
    end else begin
      m_req = id;
      if (m_gnt == 4'h0) begin m_gnt = id; tag = "R2"; end
      else if (m_gnt == id) tag = "R4";
      else tag = "R3";
    end
    if ($countones(en) > 1) tag = "R6";
  endtask

  task automatic step(logic [NP-1:0] en, logic [NP*32-1:0] d);
    @(negedge clk);
    check_all();
    wr_en = en;
    wr_data = d;
    apply(en, d);
  endtask

  function automatic logic [31:0] word(logic [3:0] id, logic [27:0] junk);
    return {junk, id};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    // R1 reset state checked by the first step
    step(3'b010, {32'h0, word(4'h5, 28'h0), 32'h0});               // R2 claim
    step(3'b100, {word(4'h7, 28'h0), 64'h0});                     // R3 other id
    step(3'b001, {64'h0, word(4'h5, 28'hABCDEF0)});               // R4 + R7 junk
    step(3'b000, '0);                                             // R9 idle
    step(3'b100, {word(4'h0, 28'hFFFFFFF), 64'h0});               // R5 release non-owner
    step(3'b110, {word(4'h9, 28'h0), word(4'h3, 28'h0), 32'h0});  // R6 port1 wins
    step(3'b011, {32'h0, word(4'h2, 28'h0), word(4'h0, 28'h0)});  // R6 port0 release wins
    step(3'b110, {word(4'h0, 28'h0), word(4'hC, 28'h0), 32'h0});  // R6 port1 claim over release
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] en;
      logic [NP*32-1:0] d;
      en = '0;
      for (int p = 0; p < NP; p++) begin
        en[p] = ($urandom % 4) == 0;
        d[p*32 +: 32] = {$urandom, 4'h0} | 32'($urandom % 5);
      end
      step(en, d);
    end
    step('0, '0);
    @(negedge clk);
    check_all();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule